// File: doc/BRIEF.md
# Transmit Line Driver High-Impedance Controller

This block decides, for each of eight transmit channels, whether the differential line driver is allowed to drive the line or must stay in high impedance. It combines a chip-wide tri-state pin, per-channel tri-state and power-down bits, a configuration-loaded handshake that follows reset, and clock-loss detection on the master clock and on every channel's transmit clock. Its output is one registered enable per channel, updated on a single reference clock, so the enable never glitches.

Clock loss is found by sampling each watched clock into the reference domain through two flip-flops and counting reference cycles between rising edges. A channel whose transmit clock has stopped is released from high impedance while it is in remote loopback or while its internal test pattern is timed from the master clock. Loss of the master clock, however, silences every channel.

The block also checks each channel's termination choice. External matching may not be combined with T1/J1 line mode, and it raises a per-channel error flag for that pairing. The flag does not affect the enables.

Top module: `lineHzTop`

## Requirements
- R1: After pin reset (`rstN` low) every `drvEn` bit is 0 and every `termErr` bit is 0. `drvEn` stays 0 until a `cfgLoad` pulse is seen. It may be 1 two reference edges after that pulse.
- R2: A `swRst` pulse forces all `drvEn` bits to 0 from the next edge. They stay 0 until a later `cfgLoad`. When `swRst` and `cfgLoad` are high in the same cycle, `swRst` wins.
- R3: While `hzPin` is 1, all `drvEn` bits are 0 from the next edge on.
- R4: `chHz[i]` at 1 clears only `drvEn[i]`. Other channels are unaffected.
- R5: `chPd[i]` at 1 clears only `drvEn[i]`. Other channels are unaffected.
- R6: Loss of the master clock clears every `drvEn` bit, whatever the loopback and pattern flags say.
- R7: Loss of transmit clock `i` clears `drvEn[i]`, unless `remLoop[i]` or `patMclk[i]` is 1.
- R8: A watched clock is declared lost after 64 reference cycles with no rising edge. It is declared present again after 8 rising edges, each arriving within 64 cycles of the one before. After reset, every clock counts as lost until it has shown those 8 edges.
- R9: `termErr[i]` equals `chExtTerm[i] AND chT1Mode[i]`, one edge after its inputs change. Here `chExtTerm[i]` = 1 selects external matching and 0 selects internal, and `chT1Mode[i]` = 1 means T1/J1 mode. `termErr` has no effect on `drvEn`.
- R10: `drvEn` is a register. A change on `hzPin`, `chHz`, `chPd`, `remLoop` or `patMclk` appears on `drvEn` at the next reference edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock for all logic |
| rstN | input | 1 | Asynchronous active-low pin reset |
| swRst | input | 1 | Synchronous software reset pulse |
| cfgLoad | input | 1 | Pulse marking that a valid configuration is in place |
| hzPin | input | 1 | Global tri-state request |
| mclkIn | input | 1 | Master clock under watch |
| txClkIn | input | 8 | Per-channel transmit clocks under watch |
| chHz | input | 8 | Per-channel tri-state request |
| chPd | input | 8 | Per-channel transmit power-down |
| chExtTerm | input | 8 | Per-channel termination select, 1 = external |
| chT1Mode | input | 8 | Per-channel line mode, 1 = T1/J1, 0 = E1 |
| remLoop | input | 8 | Per-channel remote loopback active |
| patMclk | input | 8 | Per-channel internal pattern timed by master clock |
| drvEn | output | 8 | Per-channel registered driver enable, 1 = drive |
| termErr | output | 8 | Per-channel illegal termination flag |

## Verification
The interesting overlap is a channel's transmit clock loss meeting a change of its loopback or pattern flag. The bench stops one transmit clock until the channel has tri-stated. It then raises and drops remote loopback and master-clock pattern, and judges the enable on the edge after each change: it should follow the override at once while the loss persists. The same kind of overlap is provoked between software reset and the configuration pulse by raising both in one cycle. There the enables should stay off.

// File: rtl/lineHzPkg.sv
package lineHzPkg;
  localparam int unsigned LH_CHANNELS   = 8;
  localparam int unsigned LH_LOSS_CYC   = 64;
  localparam int unsigned LH_GOOD_EDGES = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic allOff;    // chip-wide silence request
    logic cfgArmed;  // configuration loaded since last reset
  } hzStrobe_t;
endpackage

// File: rtl/lhClkLoss.sv
module lhClkLoss #(
  parameter int unsigned LOSS_CYC   = 64,
  parameter int unsigned GOOD_EDGES = 8
) (
  input  logic refClk,
  input  logic rstN,
  input  logic watchClk,
  output logic lost
);
  localparam int unsigned GW = $clog2(LOSS_CYC + 1);
  localparam int unsigned EW = (GOOD_EDGES > 1) ? $clog2(GOOD_EDGES) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(LOSS_CYC - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(GOOD_EDGES - 1);

  logic [2:0]    syncQ;
  logic [GW-1:0] gapCnt;
  logic [EW-1:0] goodCnt;
  logic          rise;
  logic          timeout;

  // two synchronizer stages plus one history stage
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], watchClk};
  end

  assign rise    = syncQ[1] & ~syncQ[2];
  assign timeout = !rise && (gapCnt >= GAP_LAST);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (rise) begin
      gapCnt <= '0;
    end else if (gapCnt != GW'(LOSS_CYC)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      lost    <= 1'b1;
      goodCnt <= '0;
    end else if (timeout) begin
      lost    <= 1'b1;
      goodCnt <= '0;
    end else if (rise && lost) begin
      if (goodCnt == EDGE_LAST) begin
        lost    <= 1'b0;
        goodCnt <= '0;
      end else begin
        goodCnt <= goodCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lhCtrl.sv
module lhCtrl
  import lineHzPkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              swRst,
  input  logic              cfgLoad,
  input  logic              hzPin,
  input  logic              mclkLost,
  input  logic [NUM_CH-1:0] txLost,
  input  logic [NUM_CH-1:0] chHz,
  input  logic [NUM_CH-1:0] chPd,
  input  logic [NUM_CH-1:0] remLoop,
  input  logic [NUM_CH-1:0] patMclk,
  output hzStrobe_t         strb,
  output logic [NUM_CH-1:0] chOff
);
  logic armed;

  // software reset has priority over a configuration load
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)        armed <= 1'b0;
    else if (swRst)   armed <= 1'b0;
    else if (cfgLoad) armed <= 1'b1;
  end

  always_comb begin
    strb.allOff   = hzPin | mclkLost | swRst;
    strb.cfgArmed = armed;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic clkExempt;
    assign clkExempt = remLoop[i] | patMclk[i];
    assign chOff[i]  = chHz[i] | chPd[i] | (txLost[i] & ~clkExempt);
  end
endmodule

// File: rtl/lhDatapath.sv
module lhDatapath
  import lineHzPkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              refClk,
  input  logic              rstN,
  input  hzStrobe_t         strb,
  input  logic [NUM_CH-1:0] chOff,
  input  logic [NUM_CH-1:0] chExtTerm,
  input  logic [NUM_CH-1:0] chT1Mode,
  output logic [NUM_CH-1:0] drvEn,
  output logic [NUM_CH-1:0] termErr
);
  logic [NUM_CH-1:0] enNext;

  assign enNext = (strb.cfgArmed && !strb.allOff) ? ~chOff : '0;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      drvEn   <= '0;
      termErr <= '0;
    end else begin
      drvEn   <= enNext;
      termErr <= chExtTerm & chT1Mode;
    end
  end
endmodule

// File: rtl/lineHzTop.sv
module lineHzTop
  import lineHzPkg::*;
#(
  parameter int unsigned NUM_CH     = LH_CHANNELS,
  parameter int unsigned LOSS_CYC   = LH_LOSS_CYC,
  parameter int unsigned GOOD_EDGES = LH_GOOD_EDGES
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              swRst,
  input  logic              cfgLoad,
  input  logic              hzPin,
  input  logic              mclkIn,
  input  logic [NUM_CH-1:0] txClkIn,
  input  logic [NUM_CH-1:0] chHz,
  input  logic [NUM_CH-1:0] chPd,
  input  logic [NUM_CH-1:0] chExtTerm,
  input  logic [NUM_CH-1:0] chT1Mode,
  input  logic [NUM_CH-1:0] remLoop,
  input  logic [NUM_CH-1:0] patMclk,
  output logic [NUM_CH-1:0] drvEn,
  output logic [NUM_CH-1:0] termErr
);
  logic              mclkLostW;
  logic [NUM_CH-1:0] txLostW;
  logic [NUM_CH-1:0] chOffW;
  hzStrobe_t         strbW;

  lhClkLoss #(.LOSS_CYC(LOSS_CYC), .GOOD_EDGES(GOOD_EDGES)) u_mclkLoss (
    .refClk(refClk), .rstN(rstN), .watchClk(mclkIn), .lost(mclkLostW)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_txLoss
    lhClkLoss #(.LOSS_CYC(LOSS_CYC), .GOOD_EDGES(GOOD_EDGES)) u_txLoss (
      .refClk(refClk), .rstN(rstN), .watchClk(txClkIn[i]), .lost(txLostW[i])
    );
  end

  lhCtrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .refClk(refClk), .rstN(rstN), .swRst(swRst), .cfgLoad(cfgLoad),
    .hzPin(hzPin), .mclkLost(mclkLostW), .txLost(txLostW),
    .chHz(chHz), .chPd(chPd), .remLoop(remLoop), .patMclk(patMclk),
    .strb(strbW), .chOff(chOffW)
  );

  lhDatapath #(.NUM_CH(NUM_CH)) u_dp (
    .refClk(refClk), .rstN(rstN), .strb(strbW), .chOff(chOffW),
    .chExtTerm(chExtTerm), .chT1Mode(chT1Mode),
    .drvEn(drvEn), .termErr(termErr)
  );
endmodule

// File: rtl/lineHzChk.sv
module lineHzChk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              refClk,
  input logic              rstN,
  input logic              swRst,
  input logic              hzPin,
  input logic              mclkLost,
  input logic [NUM_CH-1:0] chHz,
  input logic [NUM_CH-1:0] chPd,
  input logic [NUM_CH-1:0] chExtTerm,
  input logic [NUM_CH-1:0] chT1Mode,
  input logic [NUM_CH-1:0] drvEn,
  input logic [NUM_CH-1:0] termErr
);
  // R3
  hzpin_all_off_chk: assert property (@(posedge refClk) disable iff (!rstN)
    hzPin |=> (drvEn == '0));

  // R2
  swrst_all_off_chk: assert property (@(posedge refClk) disable iff (!rstN)
    swRst |=> (drvEn == '0));

  // R6
  mclk_loss_off_chk: assert property (@(posedge refClk) disable iff (!rstN)
    mclkLost |=> (drvEn == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R4
    ch_hz_off_chk: assert property (@(posedge refClk) disable iff (!rstN)
      chHz[i] |=> !drvEn[i]);

    // R5
    ch_pd_off_chk: assert property (@(posedge refClk) disable iff (!rstN)
      chPd[i] |=> !drvEn[i]);

    // R9
    term_err_chk: assert property (@(posedge refClk) disable iff (!rstN)
      $past(rstN) |-> (termErr[i] == $past(chExtTerm[i] & chT1Mode[i])));
  end
endmodule

bind lineHzTop lineHzChk #(.NUM_CH(NUM_CH)) u_chk (
  .refClk(refClk), .rstN(rstN), .swRst(swRst), .hzPin(hzPin),
  .mclkLost(mclkLostW), .chHz(chHz), .chPd(chPd),
  .chExtTerm(chExtTerm), .chT1Mode(chT1Mode),
  .drvEn(drvEn), .termErr(termErr)
);

// File: tb/lineHzTop_bench.sv
module lineHzTop_bench;
  logic       clk = 1'b0;
  logic       rstN, swRst, cfgLoad, hzPin, mclkIn;
  logic [7:0] txClkIn, chHz, chPd, chExtTerm, chT1Mode, remLoop, patMclk;
  logic [7:0] drvEn, termErr;
  logic [8:0] runClk;   // bit 8 = master clock
  int checkCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  lineHzTop u_lineHzTop (
    .refClk(clk), .rstN(rstN), .swRst(swRst), .cfgLoad(cfgLoad),
    .hzPin(hzPin), .mclkIn(mclkIn), .txClkIn(txClkIn), .chHz(chHz),
    .chPd(chPd), .chExtTerm(chExtTerm), .chT1Mode(chT1Mode),
    .remLoop(remLoop), .patMclk(patMclk), .drvEn(drvEn), .termErr(termErr)
  );

  // watched clocks: half period of 3 reference cycles while running
  initial begin
    mclkIn = 1'b0; txClkIn = '0;
    forever begin
      repeat (3) @(negedge clk);
      if (runClk[8]) mclkIn = ~mclkIn;
      for (int i = 0; i < 8; i++) if (runClk[i]) txClkIn[i] = ~txClkIn[i];
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadCfg();
    cfgLoad = 1'b1; waitCyc(1); cfgLoad = 1'b0; waitCyc(2);
  endtask

  task automatic testReset();
    check("R1 drvEn in reset", drvEn, 8'h00);
    check("R1 termErr in reset", termErr, 8'h00);
    rstN = 1'b1;
    waitCyc(120);
    check("R1 no cfgLoad yet", drvEn, 8'h00);
    check("R8 clocks found after reset", drvEn, 8'h00);
    loadCfg();
    check("R1 enabled after cfgLoad", drvEn, 8'hFF);
  endtask

  task automatic testTiming();
    chHz = 8'h04;
    #1 check("R10 no change before edge", drvEn, 8'hFF);
    waitCyc(1);
    check("R10 change after one edge", drvEn, 8'hFB);
    chHz = 8'h00; waitCyc(1);
    check("R10 restore after one edge", drvEn, 8'hFF);
  endtask

  task automatic testChannelBits();
    chHz = 8'hA5; waitCyc(1);
    check("R4 per-channel tri-state", drvEn, 8'h5A);
    chHz = 8'h00; chPd = 8'h0F; waitCyc(1);
    check("R5 per-channel power-down", drvEn, 8'hF0);
    chPd = 8'h00; waitCyc(1);
    check("R5 power-down released", drvEn, 8'hFF);
  endtask

  task automatic testGlobalPin();
    hzPin = 1'b1; waitCyc(1);
    check("R3 global pin high", drvEn, 8'h00);
    hzPin = 1'b0; waitCyc(1);
    check("R3 global pin low", drvEn, 8'hFF);
  endtask

  task automatic testSwReset();
    swRst = 1'b1; waitCyc(1); swRst = 1'b0;
    check("R2 off after swRst", drvEn, 8'h00);
    waitCyc(5);
    check("R2 still off without cfgLoad", drvEn, 8'h00);
    swRst = 1'b1; cfgLoad = 1'b1; waitCyc(1); swRst = 1'b0; cfgLoad = 1'b0;
    waitCyc(3);
    check("R2 swRst wins over cfgLoad", drvEn, 8'h00);
    loadCfg();
    check("R2 back on after cfgLoad", drvEn, 8'hFF);
  endtask

  task automatic testTxLoss();
    runClk[3] = 1'b0; waitCyc(40);
    check("R8 not lost before window", drvEn, 8'hFF);
    waitCyc(50);
    check("R7 channel 3 lost", drvEn, 8'hF7);
    remLoop[3] = 1'b1; waitCyc(1);
    check("R7 remote loopback exempts", drvEn, 8'hFF);
    remLoop[3] = 1'b0; waitCyc(1);
    check("R7 loopback released while lost", drvEn, 8'hF7);
    patMclk[3] = 1'b1; waitCyc(1);
    check("R7 master-clock pattern exempts", drvEn, 8'hFF);
    patMclk[3] = 1'b0; waitCyc(1);
    check("R7 pattern released while lost", drvEn, 8'hF7);
    runClk[3] = 1'b1; waitCyc(30);
    check("R8 too few edges to recover", drvEn, 8'hF7);
    waitCyc(80);
    check("R8 recovered after edges", drvEn, 8'hFF);
    remLoop[4] = 1'b1; runClk[4] = 1'b0; waitCyc(90);
    check("R7 loopback held through loss", drvEn, 8'hFF);
    remLoop[4] = 1'b0; waitCyc(1);
    check("R7 loss shows once loopback ends", drvEn, 8'hEF);
    runClk[4] = 1'b1; waitCyc(110);
    check("R8 channel 4 recovered", drvEn, 8'hFF);
  endtask

  task automatic testMclkLoss();
    remLoop = 8'hFF; patMclk = 8'hFF;
    runClk[8] = 1'b0; waitCyc(90);
    check("R6 master clock lost", drvEn, 8'h00);
    remLoop = 8'h00; patMclk = 8'h00;
    runClk[8] = 1'b1; waitCyc(110);
    check("R6 master clock back", drvEn, 8'hFF);
  endtask

  task automatic testTerm();
    chT1Mode = 8'h0F; chExtTerm = 8'h21; waitCyc(1);
    check("R9 error flag", termErr, 8'h01);
    check("R9 no effect on enables", drvEn, 8'hFF);
    chExtTerm = 8'hF0; waitCyc(1);
    check("R9 external in E1 legal", termErr, 8'h00);
    chT1Mode = 8'hFF; waitCyc(1);
    check("R9 mode change flags", termErr, 8'hF0);
    chExtTerm = 8'h00; waitCyc(1);
    check("R9 cleared", termErr, 8'h00);
  endtask

  initial begin
    #2000000;
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; swRst = 1'b0; cfgLoad = 1'b0; hzPin = 1'b0;
    chHz = '0; chPd = '0; chExtTerm = '0; chT1Mode = '0;
    remLoop = '0; patMclk = '0; runClk = '1;
    waitCyc(4);
    testReset();
    testTiming();
    testChannelBits();
    testGlobalPin();
    testSwReset();
    testTxLoss();
    testMclkLoss();
    testTerm();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule